// File: doc/BRIEF.md
# Chip-Enable Register and Memory-Window Peripheral

This block is a user peripheral that sits behind a simplified bus-to-IP interface, in which an upstream bridge has already turned bus transactions into a vector of per-range chip selects and per-register read and write chip enables. Range 0 holds a small bank of output registers and input ports. Range 1 is a word-addressed window onto a synchronous block RAM.

Register accesses complete in the cycle of their chip enable: a write CE loads its output register at the next rising edge and raises the write acknowledge at once, and a read CE steers its input port onto the read data bus and raises the read acknowledge at once. Memory writes also acknowledge in the same cycle. Memory reads acknowledge one cycle late, because the RAM needs one clock to present the word. That acknowledge is a single-cycle pulse. The bridge removes the chip select and CE once it sees an acknowledge, so the peripheral holds no transaction state beyond that pulse.

The interface has no valid/ready handshake. The chip select and the CE show that a request is present. The acknowledge is the only flow control: the bridge keeps the request applied until the acknowledge arrives, and the peripheral never refuses or stalls a request beyond the fixed one-cycle delay of a memory read.

Top module: `ce_periph`

## Requirements
- R1: While `rst_n` is low, and on the cycle after it rises, every output register reads zero, both acknowledges are low and the read data is zero.
- R2: On a rising edge where write CE bit i is high, output register i (bits i*DW+DW-1 down to i*DW of `gpo_o`) takes `bus_wdata_i`. Registers whose CE bit is low keep their value, even if several CE bits are high together.
- R3: `wr_ack_o` is high in every cycle in which any register write CE bit is high, with no clock delay.
- R4: When any read CE bit is high, `rd_ack_o` is high in the same cycle and `rd_data_o` carries the input port of the lowest-numbered active CE bit. With both bits of a two-register bank set, port 0 wins.
- R5: When chip select bit 1 (the memory range) is high and `bus_rnw_i` is low, the word at the window index is written at the rising edge and `wr_ack_o` is high in that cycle. Chip select bit 0 or a high `bus_rnw_i` never writes the RAM.
- R6: When chip select bit 1 is high with `bus_rnw_i` high, `rd_ack_o` rises one clock later and `rd_data_o` shows the stored word while it is high. The acknowledge is a one-cycle pulse: if the select is held, it alternates high and low.
- R7: `rd_data_o` is zero in any cycle in which `rd_ack_o` is low.
- R8: The window index is address bits 9 down to 2 (256 words of 4 bytes). All other address bits are ignored, so addresses that differ only outside those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | AW | Byte address of the access |
| bus_wdata_i | input | DW | Write data |
| bus_rnw_i | input | 1 | High for read, low for write; valid with a chip select |
| bus_cs_i | input | 2 | Chip select per range: bit 0 registers, bit 1 memory window |
| bus_rdce_i | input | NREG | Read chip enable per register |
| bus_wrce_i | input | NREG | Write chip enable per register |
| gpi_i | input | NREG*DW | Input ports, port i in slice i |
| gpo_o | output | NREG*DW | Output registers, register i in slice i |
| rd_data_o | output | DW | Read data |
| rd_ack_o | output | 1 | Read acknowledge |
| wr_ack_o | output | 1 | Write acknowledge |

## Verification
The bench holds a memory read select for several cycles on purpose. A design whose read acknowledge was a plain delayed copy of the select would keep it high and let the bridge complete two reads; the model expects it to alternate. Both read CE bits are raised together to expose a mux that picks the wrong port, and both write CE bits together to catch a bank that loads only one register. Aliased addresses and a read right after a write to the same word catch index slicing errors and a RAM that returns stale or write-through data in the wrong cycle. A design that leaves the memory data on the bus after the pulse would break the zero-when-idle rule.

// File: rtl/ce_periph_pkg.sv
package ce_periph_pkg;
  // Chip-select bit assignment; the bridge decodes address ranges in this order.
  typedef enum int unsigned {
    RANGE_REGS = 0,
    RANGE_MEM  = 1
  } range_e;

  localparam int unsigned NUM_RANGES = 2;

  // Bits of byte offset inside one data word.
  function automatic int unsigned byte_lsb(input int unsigned data_w);
    return $clog2(data_w / 8);
  endfunction
endpackage

// File: rtl/ce_regbank.sv
module ce_regbank #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        wdata_i,
  input  logic [NREG-1:0]      wrce_i,
  input  logic [NREG-1:0]      rdce_i,
  input  logic [NREG*DW-1:0]   gpi_i,
  output logic [NREG*DW-1:0]   gpo_o,
  output logic [DW-1:0]        rdata_o,
  output logic                 rd_hit_o,
  output logic                 wr_hit_o
);
  // One output register per write chip enable.
  for (genvar g = 0; g < NREG; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gpo_o[g*DW +: DW] <= '0;
      end else if (wrce_i[g]) begin
        gpo_o[g*DW +: DW] <= wdata_i;
      end
    end
  end

  // Lowest-numbered active read enable selects its port.
  always_comb begin
    rdata_o = '0;
    for (int k = NREG - 1; k >= 0; k--) begin
      if (rdce_i[k]) rdata_o = gpi_i[k*DW +: DW];
    end
  end

  assign rd_hit_o = |rdce_i;
  assign wr_hit_o = |wrce_i;
endmodule

// File: rtl/ce_ram.sv
module ce_ram #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] store [DEPTH];

  // Read-before-write synchronous port.
  always_ff @(posedge clk) begin
    if (we_i) store[idx_i] <= wdata_i;
    rdata_o <= store[idx_i];
  end
endmodule

// File: rtl/ce_memwin.sv
module ce_memwin #(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned LSB  = ce_periph_pkg::byte_lsb(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic          rnw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rd_ack_o,
  output logic          wr_ack_o
);
  logic          we;
  logic          rd_req;
  logic          ack_q;
  logic [IW-1:0] idx;
  logic [DW-1:0] ram_q;

  assign idx    = addr_i[LSB +: IW];
  assign we     = sel_i & ~rnw_i;
  assign rd_req = sel_i & rnw_i;

  ce_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .we_i    (we),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .rdata_o (ram_q)
  );

  // One-cycle delayed acknowledge, forced low after each pulse.
  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= rd_req & ~ack_q;
  end

  assign rd_ack_o = ack_q;
  assign wr_ack_o = we;
  assign rdata_o  = ack_q ? ram_q : '0;
endmodule

// File: rtl/ce_periph.sv
module ce_periph #(
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 32,
  parameter int unsigned NREG      = 2,
  parameter int unsigned MEM_WORDS = 256
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [AW-1:0]                          bus_addr_i,
  input  logic [DW-1:0]                          bus_wdata_i,
  input  logic                                   bus_rnw_i,
  input  logic [ce_periph_pkg::NUM_RANGES-1:0]   bus_cs_i,
  input  logic [NREG-1:0]                        bus_rdce_i,
  input  logic [NREG-1:0]                        bus_wrce_i,
  input  logic [NREG*DW-1:0]                     gpi_i,
  output logic [NREG*DW-1:0]                     gpo_o,
  output logic [DW-1:0]                          rd_data_o,
  output logic                                   rd_ack_o,
  output logic                                   wr_ack_o
);
  import ce_periph_pkg::*;

  logic [DW-1:0] reg_rdata;
  logic          reg_rd_hit;
  logic          reg_wr_hit;
  logic [DW-1:0] mem_rdata;
  logic          mem_rd_ack;
  logic          mem_wr_ack;
  logic          cs_regs_unused;

  // Register range relies on its CEs alone; the range select is informative.
  assign cs_regs_unused = bus_cs_i[RANGE_REGS];

  ce_regbank #(.DW(DW), .NREG(NREG)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdata_i  (bus_wdata_i),
    .wrce_i   (bus_wrce_i),
    .rdce_i   (bus_rdce_i),
    .gpi_i    (gpi_i),
    .gpo_o    (gpo_o),
    .rdata_o  (reg_rdata),
    .rd_hit_o (reg_rd_hit),
    .wr_hit_o (reg_wr_hit)
  );

  ce_memwin #(.DW(DW), .AW(AW), .DEPTH(MEM_WORDS)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (bus_cs_i[RANGE_MEM]),
    .rnw_i    (bus_rnw_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (mem_rdata),
    .rd_ack_o (mem_rd_ack),
    .wr_ack_o (mem_wr_ack)
  );

  always_comb begin
    if (reg_rd_hit) rd_data_o = reg_rdata;
    else            rd_data_o = mem_rdata;
  end

  assign rd_ack_o = reg_rd_hit | mem_rd_ack;
  assign wr_ack_o = reg_wr_hit | mem_wr_ack;
endmodule

// File: rtl/ce_periph_chk.sv
module ce_periph_chk #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [DW-1:0]       bus_wdata_i,
  input logic                bus_rnw_i,
  input logic [1:0]          bus_cs_i,
  input logic [NREG-1:0]     bus_rdce_i,
  input logic [NREG-1:0]     bus_wrce_i,
  input logic [NREG*DW-1:0]  gpo_o,
  input logic [DW-1:0]       rd_data_o,
  input logic                rd_ack_o,
  input logic                wr_ack_o
);
  // R3: register write CE acknowledged in the same cycle
  a_r3_wr_ack_now: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wrce_i != '0) |-> wr_ack_o);

  // R4: register read CE acknowledged in the same cycle
  a_r4_rd_ack_now: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdce_i != '0) |-> rd_ack_o);

  // R2: register 0 loads write data under its CE and holds otherwise
  a_r2_load0: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wrce_i[0] |=> (gpo_o[DW-1:0] == $past(bus_wdata_i)));
  a_r2_hold0: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wrce_i[0] && rst_n) |=> $stable(gpo_o[DW-1:0]));

  // R5: memory write acknowledged in the same cycle
  a_r5_mem_wr_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs_i[1] && !bus_rnw_i) |-> wr_ack_o);

  // R6: memory read acknowledge follows the select by one clock
  a_r6_mem_ack_late: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs_i[1] && bus_rnw_i && !rd_ack_o) |=> rd_ack_o);

  // R6: memory read acknowledge is a single-cycle pulse
  a_r6_mem_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack_o && bus_rdce_i == '0) |=> !(rd_ack_o && bus_rdce_i == '0));

  // R7: idle read data is zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ack_o |-> (rd_data_o == '0));
endmodule

bind ce_periph ce_periph_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wdata_i (bus_wdata_i),
  .bus_rnw_i   (bus_rnw_i),
  .bus_cs_i    (bus_cs_i),
  .bus_rdce_i  (bus_rdce_i),
  .bus_wrce_i  (bus_wrce_i),
  .gpo_o       (gpo_o),
  .rd_data_o   (rd_data_o),
  .rd_ack_o    (rd_ack_o),
  .wr_ack_o    (wr_ack_o)
);

// File: tb/sim_ce_periph.sv
module sim_ce_periph;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int NREG = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic              rnw = 1'b0;
  logic [1:0]        cs = '0;
  logic [NREG-1:0]   rdce = '0;
  logic [NREG-1:0]   wrce = '0;
  logic [NREG*DW-1:0] gpi = '0;
  logic [NREG*DW-1:0] gpo;
  logic [DW-1:0]     rdata;
  logic              rdack;
  logic              wrack;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  ce_periph #(.DW(DW), .AW(AW), .NREG(NREG), .MEM_WORDS(256)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rnw_i(rnw), .bus_cs_i(cs), .bus_rdce_i(rdce), .bus_wrce_i(wrce),
    .gpi_i(gpi), .gpo_o(gpo), .rd_data_o(rdata), .rd_ack_o(rdack),
    .wr_ack_o(wrack)
  );

  // Behavioural reference state
  logic [DW-1:0] m_out [NREG];
  logic [DW-1:0] m_mem [256];
  logic [DW-1:0] m_dout;
  bit            m_ack;

  always @(posedge clk) begin
    int idx;
    idx = int'(addr[9:2]);
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) m_out[i] = '0;
      m_ack = 0;
    end else begin
      for (int i = 0; i < NREG; i++) if (wrce[i]) m_out[i] = wdata;
      m_ack = (cs[1] && rnw && !m_ack);
      m_dout = m_mem[idx];
      if (cs[1] && !rnw) m_mem[idx] = wdata;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, one nanosecond before the next rising edge.
  always @(posedge clk) begin
    logic [DW-1:0] e_rd;
    bit e_rack, e_wack;
    string t_rd;
    #3;
    if (rdce[0])      begin e_rd = gpi[0 +: DW]; t_rd = "R4"; end
    else if (rdce[1]) begin e_rd = gpi[DW +: DW]; t_rd = "R4"; end
    else if (m_ack)   begin e_rd = m_dout;       t_rd = "R6"; end
    else              begin e_rd = '0;           t_rd = "R7"; end
    e_rack = (rdce != '0) || m_ack;
    e_wack = (wrce != '0) || (cs[1] && !rnw);
    if (!rst_n) t_rd = "R1";
    chk(t_rd, "rd_data", rdata, e_rd);
    chk(!rst_n ? "R1" : (rdce != '0 ? "R4" : "R6"), "rd_ack", {31'b0, rdack}, {31'b0, e_rack});
    chk(!rst_n ? "R1" : (wrce != '0 ? "R3" : "R5"), "wr_ack", {31'b0, wrack}, {31'b0, e_wack});
    for (int i = 0; i < NREG; i++)
      chk(!rst_n ? "R1" : "R2", "gpo", gpo[i*DW +: DW], m_out[i]);
  end

  task automatic idle();
    @(negedge clk);
    cs = '0; rnw = 0; rdce = '0; wrce = '0; addr = '0; wdata = '0;
  endtask

  task automatic reg_wr(input logic [NREG-1:0] mask, input logic [DW-1:0] d);
    @(negedge clk);
    cs = 2'b01; rnw = 0; wrce = mask; wdata = d;
    idle();
  endtask

  task automatic reg_rd(input logic [NREG-1:0] mask);
    @(negedge clk);
    cs = 2'b01; rnw = 1; rdce = mask;
    idle();
  endtask

  task automatic mem_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cs = 2'b10; rnw = 0; addr = a; wdata = d;
    idle();
  endtask

  task automatic mem_rd(input logic [AW-1:0] a, input int hold);
    @(negedge clk);
    cs = 2'b10; rnw = 1; addr = a;
    for (int i = 1; i < hold; i++) @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    gpi = {32'h1234_5678, 32'hA5A5_0F0F};
    repeat (3) @(negedge clk);           // R1 checked during reset
    rst_n = 1;
    repeat (2) @(negedge clk);           // R1 after release
    reg_wr(2'b01, 32'hDEAD_BEEF);        // R2, R3
    reg_wr(2'b10, 32'h0BAD_F00D);
    reg_wr(2'b11, 32'h5555_AAAA);        // R2 both at once
    reg_rd(2'b01);                       // R4 port 0
    reg_rd(2'b10);                       // R4 port 1
    reg_rd(2'b11);                       // R4 priority
    gpi = {32'hCAFE_0001, 32'h0000_FFFF};
    reg_rd(2'b10);
    mem_wr(32'h0000_0000, 32'h1111_1111);  // R5
    mem_wr(32'h0000_0404, 32'h2222_2222);
    mem_wr(32'h0000_03FC, 32'h3333_3333);
    mem_rd(32'h0000_0000, 1);            // R6
    mem_rd(32'hFFFF_F007, 1);            // R8 alias of index 1
    mem_rd(32'h0000_03FC, 4);            // R6 held select pulses
    mem_wr(32'h1234_5404, 32'h4444_4444);  // R8 alias overwrite
    mem_rd(32'h0000_0004, 1);
    @(negedge clk);                      // R5: read flag high with memory select -> no write
    cs = 2'b10; rnw = 1; addr = 32'h0; wdata = 32'hFFFF_FFFF;
    idle();
    @(negedge clk);                      // R5: register range select does not touch RAM
    cs = 2'b01; rnw = 0; addr = 32'h4; wdata = 32'h9999_9999;
    idle();
    mem_rd(32'h0000_0000, 1);
    mem_rd(32'h0000_0004, 2);
    for (int i = 0; i < 8; i++) mem_wr(32'(i * 4 + 32'h100), 32'(i * 32'h0101_0101));
    for (int i = 7; i >= 0; i--) mem_rd(32'(i * 4 + 32'h100), 1);
    @(negedge clk);                      // R7 idle back to zero
    rst_n = 0;
    repeat (2) @(negedge clk);           // R1 second reset
    rst_n = 1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule